// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block collects 32 interrupt request lines, lets software program each line's trigger sense, priority and destination (normal or fast interrupt), and presents one fast and one normal interrupt request to the processor. A small single-cycle register port gives software access to the captured status, the mask, the per-line settings and the number of the line currently being served. Software acknowledges a served interrupt by writing a one to the control word. Until then, the chosen line number stays frozen so that it can be read back safely.

Banks can be chained. A second-level instance is built with fast steering disabled. Its normal request output is wired to line 0 of a first-level instance. Serving a second-level interrupt then takes an acknowledge in both banks.

Top module: `intc_bank`

## Requirements
- R1: After reset every mask bit reads 1, every line setting reads 0, and both request outputs are low.
- R2: A line whose mask bit is 1 never raises a request. Writing a 0 to that bit lets the line take part in selection.
- R3: The setting word for line n sits at byte offset 0x1C + 4*n. Bit 0 = 1 steers the line to the fast path. Bit 1 = 1 selects edge sense and 0 selects level sense. Bits 6:2 hold the priority. All other bits read back as 0.
- R4: An edge-sense line latches its status bit on a rising input edge. The bit stays set after the input falls. It is cleared by acknowledging that line, or by writing 0 to that bit at status offset 0x00.
- R5: For a level-sense line, the status bit at offset 0x00 follows the live input.
- R6: Among unmasked pending lines on a path, the line with the numerically lowest priority wins. When priorities are equal, the lower line number wins.
- R7: Once a request is raised, the request and its line number (normal at 0x10, fast at 0x14) hold until that path is acknowledged, even if a more urgent line arrives.
- R8: At control offset 0x18, writing bit 0 = 1 acknowledges the normal path and writing bit 1 = 1 acknowledges the fast path, so 0x3 acknowledges both. With nothing pending, the acknowledged output is low on the next cycle.
- R9: A fast-steered line drives only the fast output. In a bank built without fast steering, bit 0 of the setting word reads 0 and the line goes to the normal path.
- R10: A second-level bank's normal request, wired to line 0 of a first-level bank, is served there as line 0. The second-level bank reports its own winning line number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 32 | Interrupt request lines |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach from the ports is a frozen winner facing a more urgent newcomer. A line has to be latched and raised first, and only then can a lower-priority-value edge arrive. The stimulus arms edge lines while they are masked, then pulses them, then unmasks them. The bench then serves the pending lines one after another and compares each winning number with the order a scoreboard predicts. A second instance, built without fast steering, feeds line 0 of the first instance so that the two-bank acknowledge sequence can be exercised.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CFG_W  = 7;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IRQNUM = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FIQNUM = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CFG0   = 8'h1C;

    // per-line setting, packed so that bit 0 = fast steer, bit 1 = edge, 6:2 = priority
    typedef struct packed {
        logic [4:0] prio;
        logic       edge_sel;
        logic       to_fiq;
    } line_cfg_t;

    function automatic logic [ADDR_W-1:0] cfg_addr(input int n);
        return OFS_CFG0 + ADDR_W'(n * 4);
    endfunction
endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NLINES = 32,
    parameter bit FIQ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NLINES-1:0] mask_q,
    output line_cfg_t         cfg_q [NLINES],
    output logic              ack_irq,
    output logic              ack_fiq,
    output logic              stat_we
);
    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (we && addr == OFS_MASK)
            mask_q <= wdata[NLINES-1:0];
    end

    assign ack_irq = we && addr == OFS_CTRL && wdata[0];
    assign ack_fiq = we && addr == OFS_CTRL && wdata[1];
    assign stat_we = we && addr == OFS_STATUS;

    for (genvar i = 0; i < NLINES; i++) begin : g_cfg
        logic steer;
        if (FIQ_EN) begin : g_fiq
            assign steer = wdata[0];
        end else begin : g_nofiq
            assign steer = 1'b0;
        end
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[i] <= '0;
            else if (we && addr == cfg_addr(i))
                cfg_q[i] <= '{prio: wdata[6:2], edge_sel: wdata[1], to_fiq: steer};
        end
    end
endmodule

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] line_in,
    input  logic [NLINES-1:0] edge_sel,
    input  logic [NLINES-1:0] ack_clr,
    input  logic              stat_we,
    input  logic [NLINES-1:0] stat_keep,
    output logic [NLINES-1:0] status
);
    logic [NLINES-1:0] prev_q;
    logic [NLINES-1:0] pend_q;
    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] keep;

    assign rise = line_in & ~prev_q & edge_sel;
    assign keep = (stat_we ? stat_keep : '1) & ~ack_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= line_in;
            pend_q <= (pend_q & keep & edge_sel) | rise;
        end
    end

    assign status = (pend_q & edge_sel) | (line_in & ~edge_sel);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NLINES = 32,
    parameter int PRIO_W = 5,
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] cand,
    input  logic [PRIO_W-1:0] prio [NLINES],
    output logic              found,
    output logic [LINE_W-1:0] win
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '1;
        win   = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (cand[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                best  = prio[i];
                win   = LINE_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_holder.sv
module intc_holder #(
    parameter int LINE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  logic              found,
    input  logic [LINE_W-1:0] win,
    output logic              active,
    output logic [LINE_W-1:0] num
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            num    <= '0;
        end else if (ack) begin
            active <= 1'b0;
        end else if (!active && found) begin
            active <= 1'b1;
            num    <= win;
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int NLINES = 32,
    parameter bit FIQ_EN = 1'b1,
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       line_in,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [NLINES-1:0] mask_q;
    line_cfg_t         cfg_q [NLINES];
    logic              ack_irq, ack_fiq, stat_we;
    logic [NLINES-1:0] edge_sel, steer, status, ack_clr;
    logic [4:0]        prio [NLINES];
    logic [NLINES-1:0] cand [2];
    logic              found [2];
    logic [LINE_W-1:0] win [2];
    logic              act [2];
    logic [LINE_W-1:0] num [2];
    logic              ack_path [2];
    logic [LINE_W-1:0] irq_num_w;

    intc_regfile #(.NLINES(NLINES), .FIQ_EN(FIQ_EN)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .mask_q(mask_q), .cfg_q(cfg_q), .ack_irq(ack_irq), .ack_fiq(ack_fiq),
        .stat_we(stat_we)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_unpack
        assign edge_sel[i] = cfg_q[i].edge_sel;
        assign steer[i]    = cfg_q[i].to_fiq;
        assign prio[i]     = cfg_q[i].prio;
    end

    intc_capture #(.NLINES(NLINES)) u_cap (
        .clk(clk), .rst(rst), .line_in(line_in[NLINES-1:0]), .edge_sel(edge_sel),
        .ack_clr(ack_clr), .stat_we(stat_we), .stat_keep(bus_wdata[NLINES-1:0]),
        .status(status)
    );

    assign cand[0]     = status & ~mask_q & ~steer;
    assign cand[1]     = status & ~mask_q & steer;
    assign ack_path[0] = ack_irq;
    assign ack_path[1] = ack_fiq;

    // path 0 = normal, path 1 = fast
    for (genvar p = 0; p < 2; p++) begin : g_path
        intc_arbiter #(.NLINES(NLINES), .PRIO_W(5)) u_arb (
            .cand(cand[p]), .prio(prio), .found(found[p]), .win(win[p])
        );
        intc_holder #(.LINE_W(LINE_W)) u_hold (
            .clk(clk), .rst(rst), .ack(ack_path[p]), .found(found[p]),
            .win(win[p]), .active(act[p]), .num(num[p])
        );
    end

    always_comb begin
        ack_clr = '0;
        if (ack_irq && act[0]) ack_clr[num[0]] = 1'b1;
        if (ack_fiq && act[1]) ack_clr[num[1]] = 1'b1;
    end

    assign irq_o     = act[0];
    assign fiq_o     = act[1];
    assign irq_num_w = num[0];

    logic [ADDR_W-1:0] cfg_off;
    assign cfg_off = bus_addr - OFS_CFG0;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STATUS: bus_rdata[NLINES-1:0] = status;
            OFS_MASK:   bus_rdata[NLINES-1:0] = mask_q;
            OFS_IRQNUM: bus_rdata[LINE_W-1:0] = num[0];
            OFS_FIQNUM: bus_rdata[LINE_W-1:0] = num[1];
            default: begin
                if (bus_addr >= OFS_CFG0 && cfg_off[1:0] == 2'b00 &&
                    int'(cfg_off[ADDR_W-1:2]) < NLINES)
                    bus_rdata[CFG_W-1:0] = cfg_q[cfg_off[2 +: LINE_W]];
            end
        endcase
    end
endmodule

// File: rtl/intc_bank_chk.sv
module intc_bank_chk #(
    parameter int NLINES = 32,
    localparam int LINE_W = $clog2(NLINES)
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [LINE_W-1:0] irq_num,
    input logic              ack_irq,
    input logic              ack_fiq,
    input logic [NLINES-1:0] mask_q
);
    logic [NLINES-1:0] mask_d;
    always_ff @(posedge clk) mask_d <= mask_q;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !irq_o && !fiq_o);

    assert_reset_mask_R1: assert property (@(posedge clk)
        $fell(rst) |-> mask_q == '1);

    assert_masked_silent_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> !mask_d[irq_num]);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o && !ack_irq |=> irq_o && $stable(irq_num));

    assert_ack_irq_R8: assert property (@(posedge clk) disable iff (rst)
        ack_irq |=> !irq_o);

    assert_ack_fiq_R8: assert property (@(posedge clk) disable iff (rst)
        ack_fiq |=> !fiq_o);
endmodule

bind intc_bank intc_bank_chk #(.NLINES(NLINES)) u_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .fiq_o(fiq_o), .irq_num(irq_num_w),
    .ack_irq(ack_irq), .ack_fiq(ack_fiq), .mask_q(mask_q)
);

// File: tb/sim_intc_bank.sv
module sim_intc_bank;
    logic        clk = 0;
    logic        rst = 1;
    logic        we0 = 0, we1 = 0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [31:0] lines0 = '0, lines1 = '0;
    logic        irq0, fiq0, irq1, fiq1;
    int          total = 0, bad = 0;
    bit          done = 0;
    int          exp_q[$];
    logic [31:0] mask0 = '1, mask1 = '1;

    always #4 clk = ~clk;

    intc_bank #(.FIQ_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .line_in({lines0[31:1], irq1}), .bus_we(we0),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata0),
        .irq_o(irq0), .fiq_o(fiq0)
    );

    intc_bank #(.FIQ_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .line_in(lines1), .bus_we(we1),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1),
        .irq_o(irq1), .fiq_o(fiq1)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int b, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (b == 0) we0 = 1; else we1 = 1;
        @(negedge clk);
        we0 = 0; we1 = 0;
    endtask

    task automatic rd(int b, logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = (b == 0) ? rdata0 : rdata1;
    endtask

    function automatic logic [7:0] cfg(int n);
        return 8'h1C + 8'(4 * n);
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_push(int n);
        exp_q.push_back(n);
    endtask

    // monitor: waits for the normal request, compares the winner, acknowledges
    task automatic serve(string req);
        logic [31:0] v;
        int exp;
        for (int k = 0; k < 20 && !irq0; k++) @(negedge clk);
        chk({req, " irq raised"}, {31'b0, irq0}, 32'd1);
        rd(0, 8'h10, v);
        exp = exp_q.pop_front();
        chk({req, " winner"}, v, exp);
        wr(0, 8'h18, 32'h1);
    endtask

    task automatic pulse0(logic [31:0] bits);
        @(negedge clk); lines0 = lines0 | bits;
        @(negedge clk); lines0 = lines0 & ~bits;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst = 0;
        idle(1);

        // R1 reset state
        rd(0, 8'h04, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(0, cfg(5), v); chk("R1 cfg", v, 32'h0);
        chk("R1 outputs", {30'b0, irq0, fiq0}, 32'h0);

        // R3 setting layout, unused bits read 0; control reads 0
        wr(0, cfg(3), 32'hFFFF_FFFF);
        rd(0, cfg(3), v); chk("R3 readback", v, 32'h7F);
        wr(0, cfg(3), 32'h0);
        rd(0, 8'h18, v); chk("R3 ctrl read", v, 32'h0);

        // R2 masked level line stays silent, R5 status live
        lines0[4] = 1'b1;
        idle(4);
        chk("R2 masked silent", {31'b0, irq0}, 32'h0);
        rd(0, 8'h00, v); chk("R5 level live", v, 32'h10);
        mask0[4] = 1'b0; wr(0, 8'h04, mask0);
        idle(3);
        chk("R2 unmasked raises", {31'b0, irq0}, 32'h1);
        rd(0, 8'h10, v); chk("R2 number", v, 32'd4);
        mask0[4] = 1'b1; wr(0, 8'h04, mask0);
        wr(0, 8'h18, 32'h1);
        chk("R8 low after ack", {31'b0, irq0}, 32'h0);
        lines0[4] = 1'b0;
        idle(1);
        rd(0, 8'h00, v); chk("R5 level follows", v, 32'h0);

        // R4 / R6 edge capture and priority ordering
        wr(0, cfg(7), 32'h2 | (3 << 2));
        wr(0, cfg(9), 32'h2 | (1 << 2));
        wr(0, cfg(10), 32'h2 | (1 << 2));
        pulse0(32'h0000_0680);
        idle(2);
        rd(0, 8'h00, v); chk("R4 latched", v, 32'h0000_0680);
        mask0[7] = 0; mask0[9] = 0; mask0[10] = 0;
        wr(0, 8'h04, mask0);
        expect_push(9); expect_push(10); expect_push(7);
        serve("R6 first");
        serve("R6 tie");
        serve("R6 last");
        chk("R8 quiet", {31'b0, irq0}, 32'h0);
        rd(0, 8'h00, v); chk("R4 ack clears", v, 32'h0);

        // R7 winner held against a more urgent newcomer
        wr(0, cfg(12), 32'h2 | (10 << 2));
        wr(0, cfg(13), 32'h2);
        mask0[12] = 0; mask0[13] = 0; wr(0, 8'h04, mask0);
        pulse0(32'h0000_1000);
        idle(4);
        rd(0, 8'h10, v); chk("R7 first", v, 32'd12);
        pulse0(32'h0000_2000);
        idle(4);
        chk("R7 still raised", {31'b0, irq0}, 32'h1);
        rd(0, 8'h10, v); chk("R7 held", v, 32'd12);
        wr(0, 8'h18, 32'h1);
        expect_push(13);
        serve("R7 next");

        // R4 status write of zero clears
        wr(0, cfg(15), 32'h2);
        pulse0(32'h0000_8000);
        idle(2);
        rd(0, 8'h00, v); chk("R4 pending", v, 32'h0000_8000);
        wr(0, 8'h00, 32'h0);
        rd(0, 8'h00, v); chk("R4 status clear", v, 32'h0);

        // R9 fast steering, R8 combined acknowledge
        wr(0, cfg(20), 32'h1 | (2 << 2));
        lines0[20] = 1; mask0[20] = 0; wr(0, 8'h04, mask0);
        idle(3);
        chk("R9 fast out", {30'b0, fiq0, irq0}, 32'h2);
        rd(0, 8'h14, v); chk("R9 fast number", v, 32'd20);
        lines0[21] = 1; mask0[21] = 0; wr(0, 8'h04, mask0);
        idle(3);
        chk("R9 both", {30'b0, fiq0, irq0}, 32'h3);
        rd(0, 8'h10, v); chk("R9 normal number", v, 32'd21);
        lines0[20] = 0; lines0[21] = 0;
        wr(0, 8'h18, 32'h3);
        chk("R8 both low", {30'b0, fiq0, irq0}, 32'h0);

        // R9 / R10 chained second bank
        wr(1, cfg(6), 32'h1);
        rd(1, cfg(6), v); chk("R9 steer ignored", v, 32'h0);
        mask1[6] = 0; wr(1, 8'h04, mask1);
        mask0[0] = 0; wr(0, 8'h04, mask0);
        lines1[6] = 1;
        idle(4);
        chk("R9 second normal", {30'b0, fiq1, irq1}, 32'h1);
        chk("R10 first raised", {31'b0, irq0}, 32'h1);
        rd(0, 8'h10, v); chk("R10 first number", v, 32'd0);
        rd(1, 8'h10, v); chk("R10 second number", v, 32'd6);
        lines1[6] = 0;
        wr(1, 8'h18, 32'h1);
        chk("R10 second low", {31'b0, irq1}, 32'h0);
        chk("R10 first held", {31'b0, irq0}, 32'h1);
        wr(0, 8'h18, 32'h1);
        idle(2);
        chk("R10 first low", {31'b0, irq0}, 32'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule